// File: doc/BRIEF.md
# Vector-Step Warp Program Sequencer

This block runs a stored list of 16-bit warp instructions. Each instruction moves a source-image window by a small signed step in x and y and names one of 64 coefficient masks to apply at the new position. The sequencer keeps the window coordinate, sends each step to the window cache and starts the multiply-accumulate datapath with the selected mask. When each result is complete it raises a strobe carrying the next output address. A reserved HALT word ends the run.

A host loads the program words and a few setup registers through a plain static-RAM style port. It then writes a start command. The unit stays busy until it reaches HALT. A step larger than one pixel on either axis inserts a fixed reload wait before the datapath starts. In two-dimensional mode each instruction takes a full kernel period. In one-dimensional mode one result leaves every clock.

Top module: `warp_seq_top`

## Requirements
- R1: After synchronous reset the unit is idle: `busy`, `step_vld`, `mac_go` and `res_vld` are low, and `win_x`/`win_y` are 0.
- R2: Host address map (8-bit address). With bit 7 clear, addresses 0..63 are program words. With bit 7 set: 0x80 is the output base address (16 bits), 0x81 the start x (9 bits), 0x82 the start y (9 bits), and 0x83 the control word (bit 0 start, write-only; bit 1 one-dimensional mode; bit 2 reads busy). Every stored value reads back on `hs_rdata` in the same cycle as `hs_cs` with `hs_we` low.
- R3: Instruction fields: bits 3:0 are the x step size, bits 7:4 the y step size, bits 13:8 the mask id, bit 14 makes the y step negative and bit 15 makes the x step negative. On the first cycle of an instruction, `step_vld` pulses and `step_dx`/`step_dy` carry the signed steps as 5-bit two's complement values.
- R4: A start loads `win_x`/`win_y` from the start registers. Each step adds the signed step modulo 512, and the result is visible from the cycle after `step_vld`. The coordinate does not change otherwise.
- R5: In two-dimensional mode (control bit 1 = 0) an instruction whose steps are both at most 1 lasts 8 cycles. `mac_go` with its mask rises together with `step_vld`, and `res_vld` comes on the 8th cycle.
- R6: In one-dimensional mode, `step_vld`, `mac_go` and `res_vld` all fall in the same cycle, so one result leaves per clock.
- R7: If either step size exceeds 1, `mac_go` is delayed by 8 reload cycles after `step_vld`, and the result timing shifts by the same amount.
- R8: The word 0xFFFF is HALT. It produces no step, no `mac_go` and no result, and `busy` falls in the following cycle. 0xFFFE is an ordinary instruction.
- R9: `res_addr` equals the output base for the first result and rises by one, modulo 2^16, for each later result.
- R10: `busy` rises in the cycle after a start write and stays high until HALT is reached.
- R11: While `busy` is high, host writes to program words and to all registers (including a second start) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_cs | input | 1 | Host select |
| hs_we | input | 1 | Host write enable |
| hs_addr | input | 8 | Host word address |
| hs_wdata | input | 16 | Host write data |
| hs_rdata | output | 16 | Host read data (combinational) |
| busy | output | 1 | Program running |
| step_vld | output | 1 | Step command to window cache |
| step_dx | output | 5 | Signed x step |
| step_dy | output | 5 | Signed y step |
| win_x | output | 9 | Current source x |
| win_y | output | 9 | Current source y |
| mac_go | output | 1 | Start of datapath accumulation |
| mac_mask | output | 6 | Mask id for the datapath |
| res_vld | output | 1 | Output pixel complete |
| res_addr | output | 16 | Address of the completed output pixel |

## Verification
The first program runs in two-dimensional mode. It mixes unit steps in every sign combination, a zero step, large steps that wrap x below zero, and the 0xFFFE word next to HALT. This tells apart the field order, the sign bits, the modular coordinate update and whether the reload wait is added. The second program runs in one-dimensional mode from a corner near 511 with a base near 2^16. It separates per-clock issue from kernel-period issue and checks coordinate and address wrap. Writes to a program word, the base and a second start are injected during the first run. They show that host access is ignored while busy, both in the unchanged timeline and in the values read back afterwards.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;
    localparam int INS_W   = 16;
    localparam int MASK_W  = 6;
    localparam int MAG_W   = 4;
    localparam int STEP_W  = MAG_W + 1;
    localparam int COORD_W = 9;
    localparam int OA_W    = 16;
    localparam logic [INS_W-1:0] HALT_WORD = '1;

    typedef struct packed {
        logic              xneg;
        logic              yneg;
        logic [MASK_W-1:0] mask;
        logic [MAG_W-1:0]  ymag;
        logic [MAG_W-1:0]  xmag;
    } warp_ins_t;

    function automatic logic signed [STEP_W-1:0] signed_step(input logic neg, input logic [MAG_W-1:0] mag);
        logic signed [STEP_W-1:0] m;
        m = $signed({1'b0, mag});
        return neg ? -m : m;
    endfunction

    function automatic logic is_far(input warp_ins_t w);
        return (w.xmag > MAG_W'(1)) || (w.ymag > MAG_W'(1));
    endfunction
endpackage

// File: rtl/warp_prog_mem.sv
module warp_prog_mem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            we,
    input  logic [AW-1:0]                   waddr,
    input  logic [warp_seq_pkg::INS_W-1:0]  wdata,
    input  logic [AW-1:0]                   raddr_a,
    input  logic [AW-1:0]                   raddr_b,
    output logic [warp_seq_pkg::INS_W-1:0]  rdata_a,
    output logic [warp_seq_pkg::INS_W-1:0]  rdata_b
);
    logic [warp_seq_pkg::INS_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/warp_axis.sv
module warp_axis
    import warp_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [COORD_W-1:0]       init,
    input  logic                     step,
    input  logic signed [STEP_W-1:0] delta,
    output logic [COORD_W-1:0]       pos
);
    always_ff @(posedge clk) begin
        if (rst)       pos <= '0;
        else if (load) pos <= init;
        else if (step) pos <= pos + {{(COORD_W-STEP_W){delta[STEP_W-1]}}, delta};
    end
endmodule

// File: rtl/warp_seq_ctrl.sv
module warp_seq_ctrl
    import warp_seq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int LANES      = 8,
    parameter int RELOAD_CYC = 8,
    parameter int PC_W       = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            mode_1d,
    input  warp_ins_t       ins,
    output logic            busy,
    output logic [PC_W-1:0] pc,
    output logic            step_vld,
    output logic            mac_go,
    output logic            res_vld
);
    localparam int EL_W = $clog2(RELOAD_CYC + LANES + 1);

    logic [EL_W-1:0] el, stall_len, period, last_el;
    logic            is_halt;

    always_comb begin
        is_halt   = (ins == warp_ins_t'(HALT_WORD));
        stall_len = is_far(ins) ? EL_W'(RELOAD_CYC) : '0;
        period    = mode_1d ? EL_W'(1) : EL_W'(LANES);
        last_el   = stall_len + period - EL_W'(1);
        step_vld  = busy && !is_halt && (el == '0);
        mac_go    = busy && !is_halt && (el == stall_len);
        res_vld   = busy && !is_halt && (el == last_el);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pc   <= '0;
            el   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pc   <= '0;
                el   <= '0;
            end
        end else if (is_halt) begin
            busy <= 1'b0;
        end else if (res_vld) begin
            pc <= pc + PC_W'(1);
            el <= '0;
        end else begin
            el <= el + EL_W'(1);
        end
    end

    assert_kernel_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (mac_go && !mode_1d) |=> !mac_go);
    assert_far_step_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (step_vld && (ins.xmag > 4'd1 || ins.ymag > 4'd1)) |-> !mac_go);
endmodule

// File: rtl/warp_seq_top.sv
module warp_seq_top
    import warp_seq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int LANES      = 8,
    parameter int RELOAD_CYC = 8,
    parameter int ADDR_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hs_cs,
    input  logic                     hs_we,
    input  logic [ADDR_W-1:0]        hs_addr,
    input  logic [INS_W-1:0]         hs_wdata,
    output logic [INS_W-1:0]         hs_rdata,
    output logic                     busy,
    output logic                     step_vld,
    output logic signed [STEP_W-1:0] step_dx,
    output logic signed [STEP_W-1:0] step_dy,
    output logic [COORD_W-1:0]       win_x,
    output logic [COORD_W-1:0]       win_y,
    output logic                     mac_go,
    output logic [MASK_W-1:0]        mac_mask,
    output logic                     res_vld,
    output logic [OA_W-1:0]          res_addr
);
    localparam int PC_W = $clog2(DEPTH);
    localparam logic [2:0] R_BASE = 3'd0, R_SX = 3'd1, R_SY = 3'd2, R_CTL = 3'd3;

    logic               prog_hit, reg_hit, wr_ok, start_cmd;
    logic [OA_W-1:0]    base_q;
    logic [COORD_W-1:0] sx_q, sy_q;
    logic               mode_q;
    logic [PC_W-1:0]    pc;
    logic [INS_W-1:0]   ins_word, host_word;
    warp_ins_t          ins;

    assign prog_hit  = !hs_addr[ADDR_W-1] && ((hs_addr >> PC_W) == '0);
    assign reg_hit   = hs_addr[ADDR_W-1] && (hs_addr[ADDR_W-2:3] == '0);
    assign wr_ok     = hs_cs && hs_we && !busy;
    assign start_cmd = wr_ok && reg_hit && (hs_addr[2:0] == R_CTL) && hs_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            sx_q   <= '0;
            sy_q   <= '0;
            mode_q <= 1'b0;
        end else if (wr_ok && reg_hit) begin
            case (hs_addr[2:0])
                R_BASE:  base_q <= hs_wdata;
                R_SX:    sx_q   <= hs_wdata[COORD_W-1:0];
                R_SY:    sy_q   <= hs_wdata[COORD_W-1:0];
                R_CTL:   mode_q <= hs_wdata[1];
                default: ;
            endcase
        end
    end

    always_comb begin
        hs_rdata = '0;
        if (hs_cs && prog_hit) hs_rdata = host_word;
        else if (hs_cs && reg_hit) begin
            case (hs_addr[2:0])
                R_BASE:  hs_rdata = base_q;
                R_SX:    hs_rdata = INS_W'(sx_q);
                R_SY:    hs_rdata = INS_W'(sy_q);
                R_CTL:   hs_rdata = INS_W'({busy, mode_q, 1'b0});
                default: hs_rdata = '0;
            endcase
        end
    end

    warp_prog_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_ok && prog_hit), .waddr(hs_addr[PC_W-1:0]), .wdata(hs_wdata),
        .raddr_a(pc), .raddr_b(hs_addr[PC_W-1:0]), .rdata_a(ins_word), .rdata_b(host_word)
    );

    assign ins = warp_ins_t'(ins_word);

    warp_seq_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .RELOAD_CYC(RELOAD_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .start(start_cmd), .mode_1d(mode_q), .ins(ins),
        .busy(busy), .pc(pc), .step_vld(step_vld), .mac_go(mac_go), .res_vld(res_vld)
    );

    assign step_dx  = signed_step(ins.xneg, ins.xmag);
    assign step_dy  = signed_step(ins.yneg, ins.ymag);
    assign mac_mask = ins.mask;

    logic [COORD_W-1:0]       ax_init  [2];
    logic [COORD_W-1:0]       ax_pos   [2];
    logic signed [STEP_W-1:0] ax_delta [2];
    assign ax_init[0] = sx_q;    assign ax_init[1] = sy_q;
    assign ax_delta[0] = step_dx; assign ax_delta[1] = step_dy;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        warp_axis u_axis (
            .clk(clk), .rst(rst), .load(start_cmd), .init(ax_init[a]),
            .step(step_vld), .delta(ax_delta[a]), .pos(ax_pos[a])
        );
    end

    assign win_x = ax_pos[0];
    assign win_y = ax_pos[1];

    always_ff @(posedge clk) begin
        if (rst)            res_addr <= '0;
        else if (start_cmd) res_addr <= base_q;
        else if (res_vld)   res_addr <= res_addr + OA_W'(1);
    end

    assert_window_still_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_vld) |=> ($stable(win_x) && $stable(win_y)));
    assert_halt_no_step_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(step_vld));
    assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !res_vld) |=> $stable(res_addr));
endmodule

// File: tb/sim_warp_seq_top.sv
`timescale 1ns/1ps
module sim_warp_seq_top;
    localparam int LEN = 512;
    localparam int KERNEL = 8;
    localparam int RELOAD = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic hs_cs = 1'b0, hs_we = 1'b0;
    logic [7:0] hs_addr = '0;
    logic [15:0] hs_wdata = '0, hs_rdata;
    logic busy, step_vld, mac_go, res_vld;
    logic signed [4:0] step_dx, step_dy;
    logic [8:0] win_x, win_y;
    logic [5:0] mac_mask;
    logic [15:0] res_addr;

    always #2.5 clk = ~clk;

    warp_seq_top u0 (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    int prog [64];
    int e_busy[LEN], e_step[LEN], e_dx[LEN], e_dy[LEN], e_mac[LEN], e_mask[LEN];
    int e_far[LEN], e_res[LEN], e_addr[LEN], e_x[LEN], e_y[LEN];
    int run_len, halt_at;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int enc(int xn, int yn, int mk, int ym, int xm);
        return (xn << 15) | (yn << 14) | (mk << 8) | (ym << 4) | xm;
    endfunction

    task automatic build(input int n, input bit one_d, input int base, input int sx, input int sy);
        int t = 0, cx = sx, cy = sy;
        for (int j = 0; j < LEN; j++) begin
            e_busy[j] = 0; e_step[j] = 0; e_mac[j] = 0; e_res[j] = 0; e_far[j] = 0;
            e_x[j] = sx; e_y[j] = sy;
        end
        for (int i = 0; i < n; i++) begin
            int w = prog[i];
            if (w == 16'hFFFF) begin
                e_busy[t] = 1; halt_at = t; run_len = t + 3;
                break;
            end else begin
                int xm = w & 15, ym = (w >> 4) & 15, mk = (w >> 8) & 63;
                int dx = w[15] ? -xm : xm;
                int dy = w[14] ? -ym : ym;
                int s = (xm > 1 || ym > 1) ? RELOAD : 0;
                int p = one_d ? 1 : KERNEL;
                for (int j = t; j < t + s + p; j++) e_busy[j] = 1;
                e_step[t] = 1; e_dx[t] = dx; e_dy[t] = dy;
                cx = ((cx + dx) % 512 + 512) % 512;
                cy = ((cy + dy) % 512 + 512) % 512;
                for (int j = t + 1; j < LEN; j++) begin e_x[j] = cx; e_y[j] = cy; end
                e_mac[t+s] = 1; e_mask[t+s] = mk; e_far[t+s] = (s != 0);
                e_res[t+s+p-1] = 1; e_addr[t+s+p-1] = (base + i) % 65536;
                t += s + p;
            end
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); hs_cs = 1; hs_we = 1; hs_addr = 8'(a); hs_wdata = 16'(d);
        @(negedge clk); hs_cs = 0; hs_we = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk); hs_cs = 1; hs_we = 0; hs_addr = 8'(a); #1;
        d = hs_rdata; hs_cs = 0;
    endtask

    task automatic run(input bit one_d, input bit inject);
        @(negedge clk); hs_cs = 1; hs_we = 1; hs_addr = 8'h83; hs_wdata = 16'(one_d ? 3 : 1);
        for (int k = 0; k < run_len; k++) begin
            @(negedge clk);
            if (k == 0) begin hs_cs = 0; hs_we = 0; end
            chk((k > halt_at) ? "R8 busy after halt" : "R10 busy", int'(busy), e_busy[k]);
            chk("R3 step strobe", int'(step_vld), e_step[k]);
            chk(one_d ? "R6 mac_go" : (e_far[k] != 0 ? "R7 mac_go after reload" : "R5 mac_go"), int'(mac_go), e_mac[k]);
            chk(one_d ? "R6 res_vld" : "R5 res_vld", int'(res_vld), e_res[k]);
            chk("R4 win_x", int'(win_x), e_x[k]);
            chk("R4 win_y", int'(win_y), e_y[k]);
            if (e_step[k] != 0) begin
                chk("R3 step_dx", int'(step_dx), e_dx[k]);
                chk("R3 step_dy", int'(step_dy), e_dy[k]);
            end
            if (e_mac[k] != 0) chk("R3 mac_mask", int'(mac_mask), e_mask[k]);
            if (e_res[k] != 0) chk("R9 res_addr", int'(res_addr), e_addr[k]);
            if (inject) begin
                hs_cs = 0; hs_we = 0;
                if (k == 3) begin hs_cs = 1; hs_we = 1; hs_addr = 8'h00; hs_wdata = 16'h1234; end
                if (k == 5) begin hs_cs = 1; hs_we = 1; hs_addr = 8'h83; hs_wdata = 16'h0003; end
                if (k == 7) begin hs_cs = 1; hs_we = 1; hs_addr = 8'h80; hs_wdata = 16'h0000; end
            end
        end
        hs_cs = 0; hs_we = 0;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int d, na, nb;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 step_vld", int'(step_vld), 0);
        chk("R1 mac_go", int'(mac_go), 0);
        chk("R1 res_vld", int'(res_vld), 0);
        chk("R1 win_x", int'(win_x), 0);
        chk("R1 win_y", int'(win_y), 0);

        // program A: two-dimensional mode
        prog[0] = enc(0,0,5,0,1);   prog[1] = enc(0,1,6,1,0);
        prog[2] = enc(1,0,7,1,1);   prog[3] = enc(0,0,0,0,0);
        prog[4] = enc(1,1,9,2,3);   prog[5] = enc(0,0,63,15,0);
        prog[6] = enc(1,0,12,0,1);  prog[7] = 16'hFFFE;
        prog[8] = 16'hFFFF;
        na = 9;
        for (int i = 0; i < na; i++) wr(i, prog[i]);
        wr(8'h80, 16'h0100); wr(8'h81, 2); wr(8'h82, 20); wr(8'h83, 0);
        for (int i = 0; i < na; i++) begin rd(i, d); chk("R2 program readback", d, prog[i]); end
        rd(8'h80, d); chk("R2 base readback", d, 16'h0100);
        rd(8'h81, d); chk("R2 start x readback", d, 2);
        rd(8'h82, d); chk("R2 start y readback", d, 20);
        rd(8'h83, d); chk("R2 control readback", d, 0);
        build(na, 1'b0, 16'h0100, 2, 20);
        run(1'b0, 1'b1);
        rd(8'h00, d); chk("R11 program word kept", d, prog[0]);
        rd(8'h80, d); chk("R11 base kept", d, 16'h0100);
        rd(8'h83, d); chk("R11 mode kept", d, 0);

        // program B: one-dimensional mode with wraps
        prog[0] = enc(0,0,1,0,1);   prog[1] = enc(0,0,2,0,1);
        prog[2] = enc(0,0,3,1,0);   prog[3] = enc(0,1,4,1,2);
        prog[4] = enc(0,0,33,0,0);  prog[5] = enc(1,1,44,1,1);
        prog[6] = 16'hFFFF;
        nb = 7;
        for (int i = 0; i < nb; i++) wr(i, prog[i]);
        wr(8'h80, 16'hFFFE); wr(8'h81, 510); wr(8'h82, 511);
        build(nb, 1'b1, 16'hFFFE, 510, 511);
        run(1'b1, 1'b0);
        rd(8'h83, d); chk("R2 control shows mode, idle", d, 2);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule